// File: doc/BRIEF.md
# Double-Buffered 10-bit Pulse-Width Modulator

This block produces one pulse-width modulated output from a free-running time base. An 8-bit step counter runs from zero up to a programmed period value. Between steps, a 2-bit sub-step count splits each step into four parts. Together the two counts form a 10-bit time base. A 2-bit prescale field slows the whole time base down. The field can leave the rate at one input clock per sub-step, or set it to 4 or 16 input clocks per sub-step.

Software programs the block through a one-cycle write port. It sets the period value, the upper eight bits of a 10-bit duty value, a control byte, and the two lower duty bits. The control byte holds the prescale field, the two lower duty bits and the enable bit.

The duty value first goes into a write buffer. At each period boundary it is copied into a shadow register, so a change made mid-period never shortens or stretches the pulse that is already running. The output goes high at the start of each period. It goes low when the time base reaches the shadow duty value.

The sequencer has three states:
- `ST_OFF`: disabled, with the counters held at zero.
- `ST_HIGH`: the output is driven high.
- `ST_LOW`: the output is driven low.

It has five transitions:
- START_HIGH (`ST_OFF`, `ST_HIGH` or `ST_LOW` to `ST_HIGH`): a period starts with a nonzero buffered duty.
- START_LOW (any of those states to `ST_LOW`): a period starts with a zero duty.
- MATCH_FALL (`ST_HIGH` to `ST_LOW`): the next time base value equals the shadow duty.
- DISABLE (any state to `ST_OFF`): the enable bit reads 0.
- HOLD: no event, so the state stays the same.

Top module: `pwm10_gen`

## Requirements
- R1: After a synchronous reset, every register is zero, the block is disabled and `pwm_out` is low. Writes that leave the enable bit at 0 keep `pwm_out` low.
- R2: A period lasts (P+1)·4·S input clocks. P is the period register. S is 1, 4 or 16, chosen by control bits [1:0]: 00 gives 1, 01 gives 4, and 10 or 11 give 16. The output rises again exactly one period after it last rose.
- R3: The duty value D is {duty-high register, control bits [3:2]}. With 0 < D < 4·(P+1), `pwm_out` is high for exactly D·S clocks at the start of each period, then low for the rest of it.
- R4: With D = 0, `pwm_out` stays low for the whole period.
- R5: With D ≥ 4·(P+1), `pwm_out` stays high for the whole period.
- R6: A duty write during a period does not change that period's pulse. The new value takes effect from the next period start.
- R7: `pwm_out` rises only at a period start, when the time base is zero. Within one period it rises at most once.
- R8: Writing 0 to the control register drives `pwm_out` low by the second rising edge after the write edge, and keeps it low. Setting enable (control bit 4) starts a fresh period on the first edge after the write edge.
- R9: The write map is as follows. Address 0 is the control register, address 1 is the period register and address 2 is the duty-high register. Writes to address 3 have no effect. A write is taken when `wr_en` is high at a rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | Modulated output |

## Verification
The main function is tried with several settings, and each one shows whether a different part is wired correctly:
- Each prescale setting, with its own period and duty. This separates a correct scaling of the sub-step count from one that only scales the step counter.
- A duty of zero, a duty exactly equal to the period length, and a duty far beyond it. These show whether the start-of-period set is suppressed and whether the clear is skipped.
- The smallest period and the largest period, with the largest duty. These expose off-by-one errors in the period-end comparison and in the 10-bit compare.
- A duty rewritten mid-period, a write to the unused address, and a disable/re-enable sequence. These separate true double buffering and correct address decoding from a design that leaks writes straight into the compare path.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } pwm_state_e;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_PERIOD = 2'd1;
    localparam logic [1:0] ADDR_DUTY   = 2'd2;

    // Prescale select to log2 of clocks per sub-step: 00 -> 0, 01 -> 2, 1x -> 4
    function automatic logic [2:0] ps_log2(input logic [1:0] sel);
        logic [2:0] r;
        unique case (sel)
            2'b00:   r = 3'd0;
            2'b01:   r = 3'd2;
            default: r = 3'd4;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwm10_regs.sv
module pwm10_regs
    import pwm10_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SUB_W = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [1:0]             wr_addr,
    input  logic [CNT_W-1:0]       wr_data,
    output logic                   en,
    output logic [1:0]             ps_sel,
    output logic [CNT_W-1:0]       period,
    output logic [CNT_W+SUB_W-1:0] duty_buf
);
    localparam int EN_BIT = 2 + SUB_W;
    localparam int CTL_W  = EN_BIT + 1;

    logic [CTL_W-1:0] ctrl_q;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] duty_hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            period_q  <= '0;
            duty_hi_q <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_CTRL:   ctrl_q    <= wr_data[CTL_W-1:0];
                ADDR_PERIOD: period_q  <= wr_data;
                ADDR_DUTY:   duty_hi_q <= wr_data;
                default:     ;
            endcase
        end
    end

    assign en       = ctrl_q[EN_BIT];
    assign ps_sel   = ctrl_q[1:0];
    assign period   = period_q;
    assign duty_buf = {duty_hi_q, ctrl_q[2 +: SUB_W]};

    // R9: the unused address must leave every register untouched
    assert_unused_addr_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd3) |=> ($stable(period) && $stable(duty_buf) && $stable(en)));

endmodule

// File: rtl/pwm10_timebase.sv
module pwm10_timebase
    import pwm10_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int SUB_W      = 2,
    parameter int PS_MAX_LOG = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   run,
    input  logic [1:0]             ps_sel,
    input  logic [CNT_W-1:0]       period,
    output logic [CNT_W+SUB_W-1:0] tb,
    output logic [CNT_W+SUB_W-1:0] tb_next,
    output logic                   period_end
);
    localparam int FINE_W = SUB_W + PS_MAX_LOG;
    localparam int TB_W   = CNT_W + SUB_W;

    logic [FINE_W-1:0] fine_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [2:0]        shift;
    logic [FINE_W:0]   span;
    logic [FINE_W-1:0] lim;
    logic [FINE_W-1:0] fine_inc;
    logic [FINE_W-1:0] cur_sh;
    logic [FINE_W-1:0] inc_sh;
    logic [SUB_W-1:0]  sub_cur;
    logic [SUB_W-1:0]  sub_nxt;
    logic              fine_wrap;

    always_comb begin
        shift     = ps_log2(ps_sel);
        span      = (FINE_W+1)'(1) << (SUB_W + int'(shift));
        lim       = FINE_W'(span - 1'b1);
        fine_inc  = fine_q + 1'b1;
        cur_sh    = fine_q >> shift;
        inc_sh    = fine_inc >> shift;
        sub_cur   = cur_sh[SUB_W-1:0];
        sub_nxt   = inc_sh[SUB_W-1:0];
        fine_wrap = (fine_q >= lim);
    end

    assign period_end = run && fine_wrap && (cnt_q >= period);
    assign tb         = {cnt_q, sub_cur};

    always_comb begin
        if (!run || period_end) begin
            tb_next = '0;
        end else if (fine_wrap) begin
            tb_next = {CNT_W'(cnt_q + 1'b1), SUB_W'(0)};
        end else begin
            tb_next = {cnt_q, sub_nxt};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            fine_q <= '0;
            cnt_q  <= '0;
        end else if (fine_wrap) begin
            fine_q <= '0;
            cnt_q  <= period_end ? '0 : CNT_W'(cnt_q + 1'b1);
        end else begin
            fine_q <= fine_inc;
        end
    end

    // R2: the step counter only moves when the sub-step count returns to zero
    assert_sub_zero_on_step_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt_q) |-> (sub_cur == '0));

    // R2: the time base never holds a value past its width while idle
    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !run |=> (tb == TB_W'(0)) || run);

endmodule

// File: rtl/pwm10_fsm.sv
module pwm10_fsm
    import pwm10_pkg::*;
#(
    parameter int TB_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [TB_W-1:0] duty_buf,
    input  logic [TB_W-1:0] tb,
    input  logic [TB_W-1:0] tb_next,
    input  logic            period_end,
    output logic            run,
    output logic            pwm_q
);
    pwm_state_e      state_q, state_d;
    logic [TB_W-1:0] shadow_q;
    logic            start;

    assign run   = en && (state_q != ST_OFF);
    assign start = en && ((state_q == ST_OFF) || period_end);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (start) state_d = (duty_buf != '0) ? ST_HIGH : ST_LOW;
            end
            ST_HIGH: begin
                if (start)                      state_d = (duty_buf != '0) ? ST_HIGH : ST_LOW;
                else if (tb_next == shadow_q)   state_d = ST_LOW;
            end
            ST_LOW: begin
                if (start) state_d = (duty_buf != '0) ? ST_HIGH : ST_LOW;
            end
            default: state_d = ST_OFF;
        endcase
        if (!en) state_d = ST_OFF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_OFF;
            shadow_q <= '0;
        end else begin
            state_q <= state_d;
            if (start) shadow_q <= duty_buf;
        end
    end

    always_comb begin
        pwm_q = (state_q == ST_HIGH);
    end

    assert_off_low_R8: assert property (@(posedge clk) disable iff (rst)
        !en |=> !pwm_q);

    assert_rise_at_start_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_q) |-> (tb == '0));

    assert_fall_at_match_R3: assert property (@(posedge clk) disable iff (rst)
        ($fell(pwm_q) && state_q != ST_OFF) |-> (tb == shadow_q));

    assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_OFF && !period_end) |=> $stable(shadow_q));

    assert_zero_low_R4: assert property (@(posedge clk) disable iff (rst)
        (shadow_q == '0) |-> !pwm_q);

endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen
    import pwm10_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int SUB_W      = 2,
    parameter int PS_MAX_LOG = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_out
);
    localparam int TB_W = CNT_W + SUB_W;

    logic             en;
    logic [1:0]       ps_sel;
    logic [CNT_W-1:0] period;
    logic [TB_W-1:0]  duty_buf;
    logic [TB_W-1:0]  tb;
    logic [TB_W-1:0]  tb_next;
    logic             period_end;
    logic             run;
    logic             pwm_q;

    pwm10_regs #(.CNT_W(CNT_W), .SUB_W(SUB_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .en       (en),
        .ps_sel   (ps_sel),
        .period   (period),
        .duty_buf (duty_buf)
    );

    pwm10_timebase #(.CNT_W(CNT_W), .SUB_W(SUB_W), .PS_MAX_LOG(PS_MAX_LOG)) u_tb (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .ps_sel     (ps_sel),
        .period     (period),
        .tb         (tb),
        .tb_next    (tb_next),
        .period_end (period_end)
    );

    pwm10_fsm #(.TB_W(TB_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .duty_buf   (duty_buf),
        .tb         (tb),
        .tb_next    (tb_next),
        .period_end (period_end),
        .run        (run),
        .pwm_q      (pwm_q)
    );

    assign pwm_out = pwm_q;

    // R1: after reset the output is low
    assert_reset_low_R1: assert property (@(posedge clk)
        rst |=> !pwm_out);

endmodule

// File: tb/sim_pwm10_gen.sv
`timescale 1ns/1ps
module sim_pwm10_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       pwm_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pwm10_gen u0 (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    // {ps_sel[1:0], period[7:0], duty[9:0]}
    localparam int NV = 9;
    localparam logic [19:0] VEC [NV] = '{
        {2'd0, 8'd3,   10'd5},
        {2'd1, 8'd2,   10'd7},
        {2'd2, 8'd1,   10'd3},
        {2'd0, 8'd4,   10'd0},
        {2'd0, 8'd2,   10'd12},
        {2'd0, 8'd2,   10'd200},
        {2'd3, 8'd0,   10'd1},
        {2'd0, 8'd0,   10'd3},
        {2'd0, 8'd255, 10'd1023}
    };

    function automatic int ps_val(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 4 : 16;
    endfunction

    function automatic int per_len(input logic [1:0] s, input logic [7:0] p);
        return (int'(p) + 1) * 4 * ps_val(s);
    endfunction

    function automatic int hi_len(input logic [1:0] s, input logic [7:0] p, input logic [9:0] d);
        if (d == 0) return 0;
        if (int'(d) >= 4 * (int'(p) + 1)) return per_len(s, p);
        return int'(d) * ps_val(s);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic measure(input int n, output int hi, output bit first, output bit single);
        bit was_low_after_high;
        bit prev;
        hi = 0; single = 1'b1; was_low_after_high = 1'b0; prev = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 0) first = pwm_out;
            if (pwm_out) begin
                hi++;
                if (was_low_after_high || (i > 0 && !prev)) single = 1'b0;
            end else if (prev) begin
                was_low_after_high = 1'b1;
            end
            prev = pwm_out;
        end
    endtask

    task automatic setup(input logic [1:0] s, input logic [7:0] p, input logic [9:0] d);
        wr(2'd1, p);
        wr(2'd2, d[9:2]);
        wr(2'd0, {4'd0, d[1:0], s});
        wr(2'd0, {3'd0, 1'b1, d[1:0], s});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int  h1, h2, n, e;
        bit  f1, f2, s1, s2;
        logic [1:0] ps;
        logic [7:0] pr;
        logic [9:0] du;

        // R1: reset state and writes with enable clear
        do_reset();
        @(negedge clk);
        check(pwm_out == 1'b0, "R1 reset output", int'(pwm_out), 0);
        wr(2'd1, 8'd3);
        wr(2'd2, 8'd2);
        wr(2'd0, 8'h0C);
        measure(20, h1, f1, s1);
        check(h1 == 0, "R1 disabled stays low", h1, 0);

        // Table-driven main function: R2 R3 R4 R5 R7
        for (int v = 0; v < NV; v++) begin
            ps = VEC[v][19:18];
            pr = VEC[v][17:10];
            du = VEC[v][9:0];
            n  = per_len(ps, pr);
            e  = hi_len(ps, pr, du);
            do_reset();
            setup(ps, pr, du);
            measure(n, h1, f1, s1);
            measure(n, h2, f2, s2);
            if (du == 0)
                check(h1 == e, "R4 zero duty high time", h1, e);
            else if (e == n)
                check(h1 == e, "R5 full-period high time", h1, e);
            else
                check(h1 == e, "R3 high time", h1, e);
            check(h2 == e, "R2 second period high time", h2, e);
            check(f2 == (du != 0), "R2 output rises after one period", int'(f2), int'(du != 0));
            check(s1 && s2, "R7 single rise per period", int'(s1 && s2), 1);
        end

        // R9: write to address 3 is ignored
        do_reset();
        wr(2'd1, 8'd3);
        wr(2'd2, 8'd1);
        wr(2'd0, 8'h05 & 8'h0C);
        wr(2'd3, 8'hFF);
        wr(2'd0, 8'h14);
        measure(16, h1, f1, s1);
        check(h1 == 5, "R9 unused address ignored high time", h1, 5);
        measure(16, h2, f2, s2);
        check(h2 == 5 && f2, "R9 unused address ignored period", h2, 5);

        // R6: duty rewritten mid-period (10 -> 20), period 32 clocks
        do_reset();
        setup(2'd0, 8'd7, 10'd10);
        h1 = 0;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            if (pwm_out) h1++;
            if (i == 3) begin
                wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'd5;
            end else if (i == 4) begin
                wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h10;
            end else if (i == 5) begin
                wr_en = 1'b0;
            end
        end
        check(h1 == 10, "R6 current period keeps old duty", h1, 10);
        measure(32, h2, f2, s2);
        check(h2 == 20, "R6 next period uses new duty", h2, 20);

        // R8: disable forces low, re-enable starts fresh period
        do_reset();
        setup(2'd0, 8'd7, 10'd20);
        measure(5, h1, f1, s1);
        wr(2'd0, 8'h00);
        @(negedge clk);
        check(pwm_out == 1'b0, "R8 low after disable", int'(pwm_out), 0);
        measure(40, h1, f1, s1);
        check(h1 == 0, "R8 stays low while disabled", h1, 0);
        wr(2'd0, 8'h10);
        measure(32, h1, f1, s1);
        check(h1 == 20 && f1, "R8 re-enable starts new period", h1, 20);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule